// File: doc/BRIEF.md
# Secure Peripheral Protection Register Bank

This block is a bank of 32-bit configuration registers that only the secure side of the system can reach. It configures ten peripheral protection controllers. Controllers 0 and 1 are the two internal APB controllers. Controllers 2 to 5 are the four APB expansion controllers. Controllers 6 to 9 are the four AHB expansion controllers. For each controller the bank stores two masks, each one bit per port:

- a non-secure mask, which marks the ports that belong to the non-secure world;
- a secure-privilege mask, which gives the required access level of the ports that stay secure.

The bank drives both masks to the controllers as per-port wires. It also takes a per-port non-secure-privilege mask from a companion register block, and chooses the final access-permission bit of each port from one of the two privilege masks.

The bank also handles the controllers' interrupt status. It gathers the status inputs into one sparse status word and keeps an interrupt enable word. A write to the clear register sends a one-cycle clear pulse to each selected controller. Two further small configuration fields drive the security response setting and the callable-region setting. A bridge enable field stores its upper half only. Twelve read-only identification bytes sit at the top of the 4 KB window.

The bus side is a plain one-cycle interface. A write takes effect on the rising clock edge on which `busSel` and `busWr` are both high. The read data is combinational from the current address, size and register state.

Top module: `pprot_bank`

## Requirements
- R1: Register offsets select one controller each. Bits [3:2] of the offset pick the index inside a 16-byte group.
  - Non-secure masks: 0x070/0x074 for controllers 0-1, 0x080-0x08C for controllers 2-5, 0x060-0x06C for controllers 6-9.
  - Secure-privilege masks: 0x0B0/0x0B4 for controllers 0-1, 0x0C0-0x0CC for controllers 2-5, 0x0A0-0x0AC for controllers 6-9.
  - A mask write keeps only the bits below that controller's port count: 3, 1 and 16 ports by default for internal controller 0, internal controller 1 and every expansion controller.
  - The stored mask reads back at the same offset. Controller c's non-secure mask appears on `nsOut[c*16 +: 16]` from the cycle after the write.
- R2: Bit p of `apOut[c*16 +: 16]` equals bit p of `nsPrivMask` when non-secure mask bit p is 1, and secure-privilege mask bit p when it is 0. Bits at or above the port count are 0.
- R3: A read of 0x020 returns the live `irqStatusIn` bits, with no delay:
  - inputs 0 and 1 at word bits 0 and 1;
  - inputs 2-5 at word bits 4-7;
  - inputs 6-9 at word bits 20-23.
  - All other word bits read 0. Writes to 0x020 have no effect.
- R4: The enable register at 0x020+8 (0x028) stores the written word ANDed with 0x00F000F3. `irqEnOut[c]` is the enable bit at controller c's position from R3.
- R5: A word write to 0x024 raises `irqClrOut[c]`, for one cycle only, for every controller c whose R3 bit position is 1 in the written word. At all other times `irqClrOut` is 0, and a read of 0x024 returns 0.
- R6: Offset 0x010 stores bit 0 of the written word and drives `respCfgOut`. Offset 0x014 stores bits [1:0] and drives `callCfgOut`.
- R7: `busSize` encodes the access width: 0 = byte, 1 = halfword, 2 or 3 = word. Writes with `busSize` 0 or 1 change no register or output.
- R8: A byte read returns byte lane `busAddr[1:0]` of the addressed word. A halfword read returns the 16 bits starting at lane `busAddr[1:0]`. A word read returns the whole word, whatever the low address bits are.
- R9: Offsets 0x040, 0x050 and 0x090 always read 0. The bridge enable at 0x048 stores only bits [31:16] of a write.
- R10: The read-only bytes at 0xFD0, 0xFD4 and so on, up to 0xFFC, read in turn 04,00,00,00,52,B8,0B,00,0D,F0,05,B1. Writes to them are ignored.
- R11: These accesses have no effect and raise no error:
  - Reads of unmapped offsets return 0.
  - Writes to unmapped offsets are ignored.
  - Word writes whose `busAddr[1:0]` is not 0 are ignored.
  - While `busSel` is low, `busRdata` is 0.
- R12: Reset (`rstN` low) clears every mask, the enable word, the bridge enable and both configuration fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 1 | Access request |
| busWr | input | 1 | 1 = write, 0 = read |
| busSize | input | 2 | Access width: 0 byte, 1 halfword, 2/3 word |
| busAddr | input | 12 | Byte offset in the 4 KB window |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data, combinational |
| nsPrivMask | input | 160 | Per-port non-secure-privilege bits, 16 per controller |
| irqStatusIn | input | 10 | Per-controller interrupt status |
| nsOut | output | 160 | Per-port non-secure outputs, 16 per controller |
| apOut | output | 160 | Per-port access-permission outputs, 16 per controller |
| irqEnOut | output | 10 | Per-controller interrupt enable |
| irqClrOut | output | 10 | Per-controller one-cycle interrupt clear |
| respCfgOut | output | 1 | Security response configuration |
| callCfgOut | output | 2 | Callable-region configuration |

## Verification
The bench writes all ones to the two internal controllers, which have only 3 ports and 1 port. A design that forgot the port-count mask would read back extra bits and drive them on `nsOut` and `apOut`.

The access-permission check covers all eight combinations of the non-secure bit, the secure-privilege bit and the non-secure-privilege bit. A design with the two mux legs swapped, or with the wrong select, fails at least one of these ports.

The sparse interrupt map is checked from both sides: through the status word and the enable outputs, and through the clear pulses. A design with shifted bit positions, or with a clear that stays asserted, is caught. Narrow writes, misaligned word writes and lane selection on narrow reads each get their own checks, since a design that decoded them loosely would overwrite configuration fields or return the wrong byte.

// File: rtl/pprot_pkg.sv
package pprot_pkg;

  localparam int NUM_CTRL = 10;
  localparam int CIDX_W   = 4;
  localparam logic [31:0] IRQ_FIELD_MASK = 32'h00F000F3;
  localparam logic [31:0] BRG_FIELD_MASK = 32'hFFFF0000;
  localparam logic [1:0]  SZ_BYTE = 2'd0;
  localparam logic [1:0]  SZ_HALF = 2'd1;

  typedef enum logic [3:0] {
    RD_ZERO, RD_NS, RD_SP, RD_STAT, RD_EN, RD_RESP, RD_CALL, RD_BRG, RD_ID
  } rdSel_e;

  typedef struct packed {
    logic [NUM_CTRL-1:0] wrNs;
    logic [NUM_CTRL-1:0] wrSp;
    logic                wrEn;
    logic                wrClr;
    logic                wrResp;
    logic                wrCall;
    logic                wrBrg;
  } strobe_t;

  // Bit position of a controller inside the interrupt status/enable/clear words
  function automatic int irqPos(input int c);
    if (c < 2)      return c;
    else if (c < 6) return c + 2;
    else            return c + 14;
  endfunction

  function automatic logic [7:0] idByte(input logic [3:0] idx);
    case (idx)
      4'd0:    return 8'h04;
      4'd4:    return 8'h52;
      4'd5:    return 8'hB8;
      4'd6:    return 8'h0B;
      4'd8:    return 8'h0D;
      4'd9:    return 8'hF0;
      4'd10:   return 8'h05;
      4'd11:   return 8'hB1;
      default: return 8'h00;
    endcase
  endfunction

endpackage

// File: rtl/pprot_ctrl.sv
module pprot_ctrl
  import pprot_pkg::*;
(
  input  logic              busSel,
  input  logic              busWr,
  input  logic [1:0]        busSize,
  input  logic [11:0]       busAddr,
  output strobe_t           stb,
  output rdSel_e            rdSel,
  output logic [CIDX_W-1:0] rdCtrl,
  output logic [3:0]        idIdx
);

  logic [7:0]        grp;
  logic [1:0]        sub;
  logic              wordWr;
  logic              isNs, isSp, isEn, isClr, isResp, isCall, isBrg;
  logic [CIDX_W-1:0] tgt;

  assign grp = busAddr[11:4];
  assign sub = busAddr[3:2];
  // Narrow writes and misaligned word writes never reach a register
  assign wordWr = busSel && busWr && (busSize != SZ_BYTE) && (busSize != SZ_HALF)
                  && (busAddr[1:0] == 2'b00);

  always_comb begin
    rdSel  = RD_ZERO;
    tgt    = '0;
    idIdx  = '0;
    isNs   = 1'b0;
    isSp   = 1'b0;
    isEn   = 1'b0;
    isClr  = 1'b0;
    isResp = 1'b0;
    isCall = 1'b0;
    isBrg  = 1'b0;
    case (grp)
      8'h01: begin
        if (sub == 2'd0) begin rdSel = RD_RESP; isResp = 1'b1; end
        if (sub == 2'd1) begin rdSel = RD_CALL; isCall = 1'b1; end
      end
      8'h02: begin
        if (sub == 2'd0) rdSel = RD_STAT;
        if (sub == 2'd1) isClr = 1'b1;
        if (sub == 2'd2) begin rdSel = RD_EN; isEn = 1'b1; end
      end
      8'h04: begin
        if (sub == 2'd2) begin rdSel = RD_BRG; isBrg = 1'b1; end
      end
      8'h06: begin rdSel = RD_NS; isNs = 1'b1; tgt = CIDX_W'(6) + CIDX_W'(sub); end
      8'h07: begin
        if (!sub[1]) begin rdSel = RD_NS; isNs = 1'b1; tgt = CIDX_W'(sub); end
      end
      8'h08: begin rdSel = RD_NS; isNs = 1'b1; tgt = CIDX_W'(2) + CIDX_W'(sub); end
      8'h0A: begin rdSel = RD_SP; isSp = 1'b1; tgt = CIDX_W'(6) + CIDX_W'(sub); end
      8'h0B: begin
        if (!sub[1]) begin rdSel = RD_SP; isSp = 1'b1; tgt = CIDX_W'(sub); end
      end
      8'h0C: begin rdSel = RD_SP; isSp = 1'b1; tgt = CIDX_W'(2) + CIDX_W'(sub); end
      8'hFD, 8'hFE, 8'hFF: begin
        rdSel = RD_ID;
        idIdx = {grp[1:0] - 2'd1, sub};
      end
      default: rdSel = RD_ZERO;
    endcase
  end

  always_comb begin
    for (int c = 0; c < NUM_CTRL; c++) begin
      stb.wrNs[c] = wordWr && isNs && (tgt == CIDX_W'(c));
      stb.wrSp[c] = wordWr && isSp && (tgt == CIDX_W'(c));
    end
    stb.wrEn   = wordWr && isEn;
    stb.wrClr  = wordWr && isClr;
    stb.wrResp = wordWr && isResp;
    stb.wrCall = wordWr && isCall;
    stb.wrBrg  = wordWr && isBrg;
  end

  assign rdCtrl = tgt;

endmodule

// File: rtl/pprot_dp.sv
module pprot_dp
  import pprot_pkg::*;
#(
  parameter int APB0_PORTS = 3,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16,
  parameter int MAXP       = 16
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobe_t                  stb,
  input  rdSel_e                   rdSel,
  input  logic [CIDX_W-1:0]        rdCtrl,
  input  logic [3:0]               idIdx,
  input  logic                     busSel,
  input  logic [1:0]               busSize,
  input  logic [1:0]               laneSel,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  input  logic [NUM_CTRL*MAXP-1:0] nsPrivMask,
  input  logic [NUM_CTRL-1:0]      irqStatusIn,
  output logic [NUM_CTRL*MAXP-1:0] nsOut,
  output logic [NUM_CTRL*MAXP-1:0] apOut,
  output logic [NUM_CTRL-1:0]      irqEnOut,
  output logic [NUM_CTRL-1:0]      irqClrOut,
  output logic                     respCfgOut,
  output logic [1:0]               callCfgOut
);

  function automatic logic [MAXP-1:0] portMask(input int c);
    int pc;
    logic [MAXP-1:0] m;
    pc = (c == 0) ? APB0_PORTS : (c == 1) ? APB1_PORTS : EXP_PORTS;
    m  = '0;
    for (int b = 0; b < MAXP; b++) if (b < pc) m[b] = 1'b1;
    return m;
  endfunction

  logic [MAXP-1:0]     nsMask [NUM_CTRL];
  logic [MAXP-1:0]     spMask [NUM_CTRL];
  logic [31:0]         enReg, brgReg, statWord;
  logic                respReg;
  logic [1:0]          callReg;
  logic [NUM_CTRL-1:0] clrReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int c = 0; c < NUM_CTRL; c++) begin
        nsMask[c] <= '0;
        spMask[c] <= '0;
      end
      enReg   <= '0;
      brgReg  <= '0;
      respReg <= 1'b0;
      callReg <= 2'b00;
      clrReg  <= '0;
    end else begin
      for (int c = 0; c < NUM_CTRL; c++) begin
        if (stb.wrNs[c]) nsMask[c] <= busWdata[MAXP-1:0] & portMask(c);
        if (stb.wrSp[c]) spMask[c] <= busWdata[MAXP-1:0] & portMask(c);
        clrReg[c] <= stb.wrClr & busWdata[irqPos(c)];
      end
      if (stb.wrEn)   enReg   <= busWdata & IRQ_FIELD_MASK;
      if (stb.wrBrg)  brgReg  <= busWdata & BRG_FIELD_MASK;
      if (stb.wrResp) respReg <= busWdata[0];
      if (stb.wrCall) callReg <= busWdata[1:0];
    end
  end

  // Per-controller outputs: non-secure bits and the privilege selection
  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_ctrl
    logic [MAXP-1:0] nsPriv;
    assign nsPriv = nsPrivMask[c*MAXP +: MAXP];
    assign nsOut[c*MAXP +: MAXP] = nsMask[c];
    assign apOut[c*MAXP +: MAXP] =
      portMask(c) & ((nsMask[c] & nsPriv) | (~nsMask[c] & spMask[c]));
    assign irqEnOut[c] = enReg[irqPos(c)];
  end

  always_comb begin
    statWord = '0;
    for (int c = 0; c < NUM_CTRL; c++) statWord[irqPos(c)] = irqStatusIn[c];
  end

  assign irqClrOut  = clrReg;
  assign respCfgOut = respReg;
  assign callCfgOut = callReg;

  logic [31:0] word, shifted;
  logic        ctrlOk;

  assign ctrlOk = (rdCtrl < CIDX_W'(NUM_CTRL));

  always_comb begin
    word = '0;
    case (rdSel)
      RD_NS:   if (ctrlOk) word[MAXP-1:0] = nsMask[rdCtrl];
      RD_SP:   if (ctrlOk) word[MAXP-1:0] = spMask[rdCtrl];
      RD_STAT: word = statWord;
      RD_EN:   word = enReg;
      RD_BRG:  word = brgReg;
      RD_RESP: word[0] = respReg;
      RD_CALL: word[1:0] = callReg;
      RD_ID:   word[7:0] = idByte(idIdx);
      default: word = '0;
    endcase
  end

  assign shifted = word >> {laneSel, 3'b000};

  always_comb begin
    if (!busSel)                  busRdata = '0;
    else if (busSize == SZ_BYTE)  busRdata = {24'h0, shifted[7:0]};
    else if (busSize == SZ_HALF)  busRdata = {16'h0, shifted[15:0]};
    else                          busRdata = word;
  end

endmodule

// File: rtl/pprot_bank.sv
module pprot_bank
  import pprot_pkg::*;
#(
  parameter int APB0_PORTS = 3,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16,
  localparam int MAXP = (EXP_PORTS >= APB0_PORTS && EXP_PORTS >= APB1_PORTS) ? EXP_PORTS :
                        (APB0_PORTS >= APB1_PORTS) ? APB0_PORTS : APB1_PORTS
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     busSel,
  input  logic                     busWr,
  input  logic [1:0]               busSize,
  input  logic [11:0]              busAddr,
  input  logic [31:0]              busWdata,
  output logic [31:0]              busRdata,
  input  logic [NUM_CTRL*MAXP-1:0] nsPrivMask,
  input  logic [NUM_CTRL-1:0]      irqStatusIn,
  output logic [NUM_CTRL*MAXP-1:0] nsOut,
  output logic [NUM_CTRL*MAXP-1:0] apOut,
  output logic [NUM_CTRL-1:0]      irqEnOut,
  output logic [NUM_CTRL-1:0]      irqClrOut,
  output logic                     respCfgOut,
  output logic [1:0]               callCfgOut
);

  strobe_t           stb;
  rdSel_e            rdSel;
  logic [CIDX_W-1:0] rdCtrl;
  logic [3:0]        idIdx;

  pprot_ctrl u_ctrl (
    .busSel (busSel),
    .busWr  (busWr),
    .busSize(busSize),
    .busAddr(busAddr),
    .stb    (stb),
    .rdSel  (rdSel),
    .rdCtrl (rdCtrl),
    .idIdx  (idIdx)
  );

  pprot_dp #(
    .APB0_PORTS(APB0_PORTS),
    .APB1_PORTS(APB1_PORTS),
    .EXP_PORTS (EXP_PORTS),
    .MAXP      (MAXP)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .rdSel      (rdSel),
    .rdCtrl     (rdCtrl),
    .idIdx      (idIdx),
    .busSel     (busSel),
    .busSize    (busSize),
    .laneSel    (busAddr[1:0]),
    .busWdata   (busWdata),
    .busRdata   (busRdata),
    .nsPrivMask (nsPrivMask),
    .irqStatusIn(irqStatusIn),
    .nsOut      (nsOut),
    .apOut      (apOut),
    .irqEnOut   (irqEnOut),
    .irqClrOut  (irqClrOut),
    .respCfgOut (respCfgOut),
    .callCfgOut (callCfgOut)
  );

endmodule

// File: rtl/pprot_bank_chk.sv
module pprot_bank_chk
  import pprot_pkg::*;
#(
  parameter int APB0_PORTS = 3,
  parameter int APB1_PORTS = 1,
  parameter int EXP_PORTS  = 16,
  parameter int MAXP       = 16
) (
  input logic                     clk,
  input logic                     rstN,
  input logic                     busSel,
  input logic                     busWr,
  input logic [1:0]               busSize,
  input logic [11:0]              busAddr,
  input logic [31:0]              busRdata,
  input logic [NUM_CTRL*MAXP-1:0] nsOut,
  input logic [NUM_CTRL*MAXP-1:0] apOut,
  input logic [NUM_CTRL-1:0]      irqEnOut,
  input logic [NUM_CTRL-1:0]      irqClrOut,
  input logic                     respCfgOut,
  input logic [1:0]               callCfgOut
);

  logic wordReq, narrowWr;
  assign wordReq  = busSel && busWr && (busSize != SZ_BYTE) && (busSize != SZ_HALF);
  assign narrowWr = busSel && busWr && ((busSize == SZ_BYTE) || (busSize == SZ_HALF));

  // R7: narrow writes leave every configuration output untouched
  a_r7_narrow_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    narrowWr |=> ($stable(nsOut) && $stable(respCfgOut) && $stable(callCfgOut) && $stable(irqEnOut)));

  // R5: clear pulses appear only in the cycle after a clear write
  a_r5_clear_only_after_write: assert property (@(posedge clk) disable iff (!rstN)
    !(wordReq && busAddr == 12'h024) |=> (irqClrOut == '0));

  // R6: configuration outputs move only on their own writes
  a_r6_resp_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wordReq && busAddr == 12'h010) |=> $stable(respCfgOut));
  a_r6_call_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wordReq && busAddr == 12'h014) |=> $stable(callCfgOut));

  // R4: enables move only on an enable write
  a_r4_enable_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(wordReq && busAddr == 12'h028) |=> $stable(irqEnOut));

  // R11: idle bus returns zero
  a_r11_idle_rdata: assert property (@(posedge clk) disable iff (!rstN)
    !busSel |-> (busRdata == '0));

  // R1 / R2: no output bit above a controller's port count is ever set
  for (genvar c = 0; c < NUM_CTRL; c++) begin : g_bound
    localparam int PC = (c == 0) ? APB0_PORTS : (c == 1) ? APB1_PORTS : EXP_PORTS;
    logic [MAXP-1:0] outside;
    always_comb begin
      outside = '0;
      for (int b = 0; b < MAXP; b++) if (b >= PC) outside[b] = 1'b1;
    end
    a_r1_ns_bounds: assert property (@(posedge clk) disable iff (!rstN)
      (nsOut[c*MAXP +: MAXP] & outside) == '0);
    a_r2_ap_bounds: assert property (@(posedge clk) disable iff (!rstN)
      (apOut[c*MAXP +: MAXP] & outside) == '0);
  end

endmodule

bind pprot_bank pprot_bank_chk #(
  .APB0_PORTS(APB0_PORTS),
  .APB1_PORTS(APB1_PORTS),
  .EXP_PORTS (EXP_PORTS),
  .MAXP      (MAXP)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .busSel    (busSel),
  .busWr     (busWr),
  .busSize   (busSize),
  .busAddr   (busAddr),
  .busRdata  (busRdata),
  .nsOut     (nsOut),
  .apOut     (apOut),
  .irqEnOut  (irqEnOut),
  .irqClrOut (irqClrOut),
  .respCfgOut(respCfgOut),
  .callCfgOut(callCfgOut)
);

// File: tb/pprot_bank_test.sv
`timescale 1ns/1ps
module pprot_bank_test;

  localparam int NC = 10;
  localparam int MP = 16;

  logic            clk = 1'b0;
  logic            rstN = 1'b0;
  logic            busSel = 1'b0;
  logic            busWr = 1'b0;
  logic [1:0]      busSize = 2'd2;
  logic [11:0]     busAddr = '0;
  logic [31:0]     busWdata = '0;
  logic [31:0]     busRdata;
  logic [NC*MP-1:0] nsPrivMask = '0;
  logic [NC-1:0]   irqStatusIn = '0;
  logic [NC*MP-1:0] nsOut, apOut;
  logic [NC-1:0]   irqEnOut, irqClrOut;
  logic            respCfgOut;
  logic [1:0]      callCfgOut;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pprot_bank uut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWr(busWr), .busSize(busSize),
    .busAddr(busAddr), .busWdata(busWdata), .busRdata(busRdata),
    .nsPrivMask(nsPrivMask), .irqStatusIn(irqStatusIn), .nsOut(nsOut), .apOut(apOut),
    .irqEnOut(irqEnOut), .irqClrOut(irqClrOut), .respCfgOut(respCfgOut),
    .callCfgOut(callCfgOut)
  );

  typedef struct packed {
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  // Word write, then word read-back of the same offset
  localparam vec_t VECS [16] = '{
    '{12'h070, 32'hFFFFFFFF, 32'h00000007, 4'd1},  // R1 internal 0, 3 ports
    '{12'h074, 32'hFFFFFFFF, 32'h00000001, 4'd1},  // R1 internal 1, 1 port
    '{12'h080, 32'h12345678, 32'h00005678, 4'd1},  // R1 expansion truncation
    '{12'h08C, 32'hFFFFFFFF, 32'h0000FFFF, 4'd1},
    '{12'h060, 32'h0001ABCD, 32'h0000ABCD, 4'd1},
    '{12'h0B0, 32'h00000005, 32'h00000005, 4'd1},
    '{12'h0AC, 32'hFFFF0F0F, 32'h00000F0F, 4'd1},
    '{12'h028, 32'hFFFFFFFF, 32'h00F000F3, 4'd4},  // R4
    '{12'h048, 32'h12345678, 32'h12340000, 4'd9},  // R9 bridge enable
    '{12'h010, 32'hFFFFFFFF, 32'h00000001, 4'd6},  // R6
    '{12'h014, 32'hFFFFFFFF, 32'h00000003, 4'd6},
    '{12'h040, 32'hFFFFFFFF, 32'h00000000, 4'd9},  // R9 zero
    '{12'h050, 32'hFFFFFFFF, 32'h00000000, 4'd9},
    '{12'h090, 32'hFFFFFFFF, 32'h00000000, 4'd9},
    '{12'h078, 32'hFFFFFFFF, 32'h00000000, 4'd11}, // R11 hole in group
    '{12'h200, 32'hFFFFFFFF, 32'h00000000, 4'd11}  // R11 unmapped
  };

  localparam logic [7:0] IDS [12] = '{8'h04, 8'h00, 8'h00, 8'h00, 8'h52, 8'hB8,
                                      8'h0B, 8'h00, 8'h0D, 8'hF0, 8'h05, 8'hB1};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [11:0] a, input logic [31:0] d, input logic [1:0] sz);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b1; busAddr = a; busWdata = d; busSize = sz;
    @(negedge clk);
    busSel = 1'b0; busWr = 1'b0;
    #1;
  endtask

  task automatic busRead(input logic [11:0] a, input logic [1:0] sz, output logic [31:0] d);
    @(negedge clk);
    busSel = 1'b1; busWr = 1'b0; busAddr = a; busSize = sz;
    #1 d = busRdata;
    busSel = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    #1;
    // R12 reset state
    chk("R12 nsOut", {31'b0, |nsOut}, 32'h0);
    chk("R12 enable", {22'b0, irqEnOut}, 32'h0);
    chk("R12 cfg", {29'b0, callCfgOut, respCfgOut}, 32'h0);
    busRead(12'h070, 2'd2, rd); chk("R12 mask read", rd, 32'h0);

    // Table walk
    for (int i = 0; i < 16; i++) begin
      busWrite(VECS[i].addr, VECS[i].wdata, 2'd2);
      busRead(VECS[i].addr, 2'd2, rd);
      checks++;
      if (rd !== VECS[i].exp) begin
        failures++;
        $display("FAIL R%0d table[%0d] act=%h exp=%h", VECS[i].req, i, rd, VECS[i].exp);
      end
    end
    chk("R1 nsOut ctrl0", {16'b0, nsOut[0 +: 16]}, 32'h7);
    chk("R1 nsOut ctrl2", {16'b0, nsOut[32 +: 16]}, 32'h5678);
    chk("R4 irqEnOut all", {22'b0, irqEnOut}, 32'h3FF);
    chk("R6 respCfgOut", {31'b0, respCfgOut}, 32'h1);
    chk("R6 callCfgOut", {30'b0, callCfgOut}, 32'h3);

    // R2 all eight combinations on controller 2
    nsPrivMask[32 +: 16] = 16'h00AA;
    busWrite(12'h080, 32'h000000F0, 2'd2);
    busWrite(12'h0C0, 32'h000000CC, 2'd2);
    chk("R2 ap mux ctrl2", {16'b0, apOut[32 +: 16]}, 32'h00AC);
    chk("R1 ns ctrl2", {16'b0, nsOut[32 +: 16]}, 32'h00F0);
    // R2 truncation on controller 0 (ns=7, sp=5)
    busWrite(12'h070, 32'hFFFFFFFF, 2'd2);
    nsPrivMask[0 +: 16] = 16'hFFFF;
    #1 chk("R2 ap ctrl0 ns side", {16'b0, apOut[0 +: 16]}, 32'h7);
    busWrite(12'h070, 32'h0, 2'd2);
    chk("R2 ap ctrl0 sp side", {16'b0, apOut[0 +: 16]}, 32'h5);

    // R3 status mapping
    irqStatusIn = 10'b1010000011;
    busRead(12'h020, 2'd2, rd); chk("R3 status a", rd, 32'h00A00003);
    irqStatusIn = 10'b0000001100;
    busWrite(12'h020, 32'hFFFFFFFF, 2'd2);
    busRead(12'h020, 2'd2, rd); chk("R3 status b", rd, 32'h00000030);

    // R4 enable positions
    busWrite(12'h028, 32'h00100010, 2'd2);
    chk("R4 irqEnOut sparse", {22'b0, irqEnOut}, 32'h044);

    // R5 clear pulse
    busWrite(12'h024, 32'h00200002, 2'd2);
    chk("R5 clear pulse", {22'b0, irqClrOut}, 32'h082);
    @(negedge clk); #1;
    chk("R5 clear drops", {22'b0, irqClrOut}, 32'h0);
    busRead(12'h024, 2'd2, rd); chk("R5 clear reads zero", rd, 32'h0);

    // R7 narrow writes ignored
    busWrite(12'h014, 32'h0, 2'd0);
    chk("R7 byte write ignored", {30'b0, callCfgOut}, 32'h3);
    busWrite(12'h0B0, 32'h0, 2'd1);
    busRead(12'h0B0, 2'd2, rd); chk("R7 half write ignored", rd, 32'h5);

    // R8 lane extraction
    busWrite(12'h048, 32'hA5C31234, 2'd2);
    busRead(12'h04B, 2'd0, rd); chk("R8 byte lane3", rd, 32'hA5);
    busRead(12'h04A, 2'd0, rd); chk("R8 byte lane2", rd, 32'hC3);
    busRead(12'h04A, 2'd1, rd); chk("R8 half upper", rd, 32'hA5C3);
    busRead(12'h048, 2'd1, rd); chk("R8 half lower", rd, 32'h0);
    busRead(12'h04A, 2'd2, rd); chk("R8 word ignores low bits", rd, 32'hA5C30000);

    // R10 identification bytes
    for (int i = 0; i < 12; i++) begin
      busRead(12'hFD0 + 12'(4*i), 2'd2, rd);
      chk("R10 id byte", rd, {24'b0, IDS[i]});
    end
    busWrite(12'hFD0, 32'hFFFFFFFF, 2'd2);
    busRead(12'hFD0, 2'd2, rd); chk("R10 id write ignored", rd, 32'h04);

    // R11 misaligned write and idle read
    busWrite(12'h011, 32'h0, 2'd2);
    chk("R11 misaligned ignored", {31'b0, respCfgOut}, 32'h1);
    @(negedge clk);
    busSel = 1'b0; busAddr = 12'h028; busSize = 2'd2;
    #1 chk("R11 idle rdata", busRdata, 32'h0);

    // R12 reset mid-run
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    #1;
    chk("R12 nsOut cleared", {31'b0, |nsOut}, 32'h0);
    chk("R12 enable cleared", {22'b0, irqEnOut}, 32'h0);
    chk("R12 cfg cleared", {29'b0, callCfgOut, respCfgOut}, 32'h0);
    busRead(12'h0C0, 2'd2, rd); chk("R12 sp cleared", rd, 32'h0);
    busRead(12'h048, 2'd2, rd); chk("R12 bridge cleared", rd, 32'h0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule